// File: doc/BRIEF.md
# Masked Data Breakpoint Matcher

This block watches the data accesses of a processor core. It compares each load or store against a set of breakpoint channels. There are two channels by default. Each channel has a 32-bit watch address and a 32-bit control word. The control word holds a load-enable bit, a store-enable bit and a 6-bit compare mask for the low address bits. A zero mask bit widens the watched region. The access width then widens the access. An access hits a channel when any byte it touches falls inside that channel's watched region.

Accesses enter on a valid/ready input. Results leave on a valid/ready output through one register stage. The input is ready whenever the result register is empty or is being drained in the same cycle. A result held under back-pressure stays unchanged. While it is held, the input is not ready. Each result carries a hit flag, the index of the lowest-numbered channel that hit, and the cause word for the exception logic. The watch and control words are plain configuration inputs.

Top module: `dbrk_watch`

## Requirements
- R1: A channel can hit a load only when its control bit 30 is 1. It can hit a store only when its control bit 31 is 1. `acc_store` = 1 marks a store.
- R2: Address bits 31:6 are always compared exactly. A difference there never hits.
- R3: `acc_size` gives the access width: 0 means 1 byte, 1 means 2 bytes, 2 or 3 means 4 bytes. A 2-byte access ignores address bit 0 and a 4-byte access ignores address bits 1:0. For example, a 2-byte load at 0x7c hits a one-byte watch (mask 0x3f) at 0x7d, and a 4-byte load at 0x74 hits a 32-byte watch (mask 0x20) at 0x60.
- R4: Control bits 5:0 are a compare mask for address bits 5:0. A 1 compares the bit and a 0 ignores it, on both the watch address and the access address. For example, a 16-byte watch (mask 0x30) with address 0x71 hits a 2-byte load at 0x70.
- R5: A non-contiguous mask is honoured bit by bit. For example, mask 0x35 at 0x72 hits a 4-byte load at 0x70.
- R6: When several channels hit, `res_chan` reports the lowest index.
- R7: On a hit, `res_cause` is 0x4 OR (channel index shifted left by 8). On a miss, `res_hit`, `res_chan` and `res_cause` are all 0.
- R8: An access accepted at a clock edge (`acc_valid` and `acc_ready` both 1) has its result on the outputs with `res_valid` = 1 right after that edge. `acc_ready` is 1 exactly when `res_valid` is 0 or `res_ready` is 1.
- R9: While `res_valid` is 1 and `res_ready` is 0, the result outputs hold their values and `acc_ready` is 0.
- R10: During reset, `res_valid` is 0 and `acc_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| brk_addr | input | NUM_CH*32 | Watch address per channel, channel 0 in the low word |
| brk_ctrl | input | NUM_CH*32 | Control word per channel: bit 31 store enable, bit 30 load enable, bits 5:0 compare mask |
| acc_valid | input | 1 | Access is presented |
| acc_ready | output | 1 | Access can be accepted this cycle |
| acc_addr | input | 32 | Effective address of the access |
| acc_size | input | 2 | Access width code |
| acc_store | input | 1 | 1 for a store, 0 for a load |
| res_valid | output | 1 | Result is present |
| res_ready | input | 1 | Consumer takes the result |
| res_hit | output | 1 | At least one channel hit |
| res_chan | output | CH_W | Lowest channel that hit |
| res_cause | output | 32 | Cause word for the exception logic |

## Verification
The result of an accepted access is due just after the accepting edge. The bench drives each access half a cycle before an edge and samples the outputs at the falling edge that follows, so every result is checked exactly one edge after its handshake. For the back-pressure sequence, `acc_ready` is read at a falling edge while a result is stalled. The held outputs are compared again one full cycle later. After `res_ready` is released, the next result is checked one edge later.

// File: rtl/dbm_pkg.sv
package dbm_pkg;
  localparam int unsigned CTRL_W     = 32;
  localparam int unsigned CAUSE_W    = 32;
  localparam int unsigned LD_EN_BIT  = 30;
  localparam int unsigned ST_EN_BIT  = 31;
  localparam int unsigned CAUSE_DATA = 4;
  localparam int unsigned CAUSE_CH_SHIFT = 8;

  // low address bits the access width makes irrelevant
  function automatic logic [1:0] width_ignore(input logic [1:0] sz);
    case (sz)
      2'd0:    return 2'b00;
      2'd1:    return 2'b01;
      default: return 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/dbm_chan_match.sv
module dbm_chan_match #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic              acc_store,
  input  logic [ADDR_W-1:0] watch_addr,
  input  logic [MASK_W-1:0] watch_mask,
  input  logic              ld_en,
  input  logic              st_en,
  output logic              match
);
  import dbm_pkg::*;

  logic [ADDR_W-1:0] cmp_bits;
  logic              kind_en;

  always_comb begin
    cmp_bits = '1;
    cmp_bits[MASK_W-1:0] = watch_mask;
    cmp_bits[1:0] = cmp_bits[1:0] & ~width_ignore(acc_size);
  end

  assign kind_en = acc_store ? st_en : ld_en;
  assign match   = kind_en && (((acc_addr ^ watch_addr) & cmp_bits) == '0);

  assert_kind_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_store ? !st_en : !ld_en) |-> !match);

  assert_upper_exact_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr[ADDR_W-1:MASK_W] != watch_addr[ADDR_W-1:MASK_W]) |-> !match);
endmodule

// File: rtl/dbm_prio.sv
module dbm_prio #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CH_W   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] hit_vec,
  output logic              any_hit,
  output logic [CH_W-1:0]   sel,
  output logic [31:0]       cause
);
  import dbm_pkg::*;

  always_comb begin
    sel = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel = CH_W'(i);
    end
  end

  assign any_hit = |hit_vec;
  assign cause   = any_hit ? (32'(CAUSE_DATA) | (32'(sel) << CAUSE_CH_SHIFT)) : 32'd0;

  assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vec[0] |-> (sel == '0));
endmodule

// File: rtl/dbm_out_reg.sv
module dbm_out_reg #(
  parameter int unsigned CH_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_hit,
  input  logic [CH_W-1:0] in_chan,
  input  logic [31:0]     in_cause,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_hit,
  output logic [CH_W-1:0] out_chan,
  output logic [31:0]     out_cause
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_chan  <= '0;
      out_cause <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_hit   <= in_hit;
      out_chan  <= in_chan;
      out_cause <= in_cause;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_next_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) &&
                                   $stable(out_chan) && $stable(out_cause)));

  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_cause == 32'd0 && out_chan == '0));
endmodule

// File: rtl/dbrk_watch.sv
module dbrk_watch #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned MASK_W = 6,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_CH*ADDR_W-1:0]   brk_addr,
  input  logic [NUM_CH*32-1:0]       brk_ctrl,
  input  logic                       acc_valid,
  output logic                       acc_ready,
  input  logic [ADDR_W-1:0]          acc_addr,
  input  logic [1:0]                 acc_size,
  input  logic                       acc_store,
  output logic                       res_valid,
  input  logic                       res_ready,
  output logic                       res_hit,
  output logic [CH_W-1:0]            res_chan,
  output logic [31:0]                res_cause
);
  import dbm_pkg::*;

  logic [NUM_CH-1:0] hit_vec;
  logic              any_hit;
  logic [CH_W-1:0]   sel;
  logic [31:0]       cause;
  logic              unused_ctrl_bits;

  assign unused_ctrl_bits = ^brk_ctrl;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic [CTRL_W-1:0] ctrl_w;
    assign ctrl_w = brk_ctrl[c*CTRL_W +: CTRL_W];
    dbm_chan_match #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_match (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_addr   (acc_addr),
      .acc_size   (acc_size),
      .acc_store  (acc_store),
      .watch_addr (brk_addr[c*ADDR_W +: ADDR_W]),
      .watch_mask (ctrl_w[MASK_W-1:0]),
      .ld_en      (ctrl_w[LD_EN_BIT]),
      .st_en      (ctrl_w[ST_EN_BIT]),
      .match      (hit_vec[c])
    );
  end

  dbm_prio #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_prio (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_vec (hit_vec),
    .any_hit (any_hit),
    .sel     (sel),
    .cause   (cause)
  );

  dbm_out_reg #(.CH_W(CH_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (acc_valid),
    .in_ready  (acc_ready),
    .in_hit    (any_hit),
    .in_chan   (sel),
    .in_cause  (cause),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_hit   (res_hit),
    .out_chan  (res_chan),
    .out_cause (res_cause)
  );
endmodule

// File: tb/dbrk_watch_bench.sv
module dbrk_watch_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] brk_addr = '0;
  logic [63:0] brk_ctrl = '0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic        acc_store = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_hit;
  logic [0:0]  res_chan;
  logic [31:0] res_cause;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbrk_watch u_dbrk_watch (
    .clk(clk), .rst_n(rst_n), .brk_addr(brk_addr), .brk_ctrl(brk_ctrl),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_store(acc_store), .res_valid(res_valid),
    .res_ready(res_ready), .res_hit(res_hit), .res_chan(res_chan),
    .res_cause(res_cause)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // byte-by-byte overlap model: returns {hit, chan}
  function automatic logic [1:0] model(input logic [31:0] a, input logic [1:0] sz,
                                       input logic st);
    int n = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    logic [31:0] start = a & ~(32'(n) - 32'd1);
    for (int ch = 0; ch < 2; ch++) begin
      logic [31:0] ctl = brk_ctrl[ch*32 +: 32];
      logic [31:0] w   = brk_addr[ch*32 +: 32];
      logic [31:0] cmp = {26'h3ffffff, ctl[5:0]};
      if (st ? ctl[31] : ctl[30]) begin
        for (int b = 0; b < n; b++) begin
          if ((((start + 32'(b)) ^ w) & cmp) == 32'd0) return {1'b1, 1'(ch)};
        end
      end
    end
    return 2'b00;
  endfunction

  task automatic set_ch(input int ch, input logic [31:0] ctl, input logic [31:0] w);
    brk_ctrl[ch*32 +: 32] = ctl;
    brk_addr[ch*32 +: 32] = w;
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input logic st,
                        input string req);
    logic [1:0] e = model(a, sz, st);
    logic [31:0] ecause = e[1] ? (32'h4 | (32'(e[0]) << 8)) : 32'h0;
    acc_addr = a; acc_size = sz; acc_store = st; acc_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    chk({req, " valid R8"}, 32'(res_valid), 32'd1);
    chk({req, " hit"}, 32'(res_hit), 32'(e[1]));
    chk({req, " chan R6"}, 32'(res_chan), 32'(e[0]));
    chk({req, " cause R7"}, res_cause, ecause);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R10 reset res_valid", 32'(res_valid), 32'd0);
    chk("R10 reset acc_ready", 32'(acc_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 directed overlap cases, channel 1 idle
    set_ch(1, 32'h0, 32'h0);
    set_ch(0, 32'h4000003f, 32'hd000007d);
    access(32'hd000007c, 2'd1, 1'b0, "R3 half over byte");
    chk("R3 half over byte hit", 32'(res_hit), 32'd1);
    access(32'hd000007c, 2'd0, 1'b0, "R3 byte miss");
    chk("R3 byte miss", 32'(res_hit), 32'd0);
    set_ch(0, 32'h40000020, 32'hd0000060);
    access(32'hd0000074, 2'd2, 1'b0, "R3 word in 32B");
    chk("R3 word in 32B hit", 32'(res_hit), 32'd1);
    // R4 watch bits under zero mask ignored
    set_ch(0, 32'h40000030, 32'hd0000071);
    access(32'hd0000070, 2'd1, 1'b0, "R4 16B watch odd base");
    chk("R4 hit", 32'(res_hit), 32'd1);
    // R5 non-contiguous mask
    set_ch(0, 32'h40000035, 32'hd0000072);
    access(32'hd0000070, 2'd2, 1'b0, "R5 mask 0x35");
    chk("R5 hit", 32'(res_hit), 32'd1);
    // R2 upper bits exact even with empty mask
    set_ch(0, 32'hc0000000, 32'hd0000070);
    access(32'hd0800070, 2'd0, 1'b0, "R2 upper differ");
    chk("R2 miss", 32'(res_hit), 32'd0);
    // R1 load-only channel ignores store
    set_ch(0, 32'h4000003f, 32'h00001000);
    access(32'h00001000, 2'd0, 1'b1, "R1 store on load-only");
    chk("R1 store miss", 32'(res_hit), 32'd0);
    set_ch(0, 32'h8000003f, 32'h00001000);
    access(32'h00001000, 2'd0, 1'b1, "R1 store on store-only");
    chk("R1 store hit", 32'(res_hit), 32'd1);
    // R6/R7 priority and cause
    set_ch(0, 32'h4000003c, 32'h00002000);
    set_ch(1, 32'h4000003c, 32'h00002000);
    access(32'h00002002, 2'd0, 1'b0, "R6 both hit");
    chk("R6 chan0 wins", 32'(res_chan), 32'd0);
    set_ch(0, 32'h0000003c, 32'h00002000);
    access(32'h00002002, 2'd0, 1'b0, "R7 only ch1");
    chk("R7 cause ch1", res_cause, 32'h00000104);

    // R9 back-pressure
    res_ready = 1'b0;
    access(32'h00002001, 2'd0, 1'b0, "R9 first");
    acc_addr = 32'h00009000; acc_size = 2'd0; acc_store = 1'b0; acc_valid = 1'b1;
    chk("R9 acc_ready low while stalled", 32'(acc_ready), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R9 held valid", 32'(res_valid), 32'd1);
    chk("R9 held hit", 32'(res_hit), 32'd1);
    chk("R9 held cause", res_cause, 32'h00000104);
    chk("R8 ready follows res_ready", 32'(acc_ready), 32'd0);
    res_ready = 1'b1;
    #1;
    chk("R8 ready when drained", 32'(acc_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    chk("R9 next result valid", 32'(res_valid), 32'd1);
    chk("R9 next result miss", 32'(res_hit), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R8 drained", 32'(res_valid), 32'd0);

    // random traffic
    for (int i = 0; i < 400; i++) begin
      if (i % 8 == 0) begin
        for (int ch = 0; ch < 2; ch++) begin
          logic [31:0] r = $urandom;
          set_ch(ch, {r[31:30], 24'h0, r[5:0]}, $urandom);
        end
      end
      begin
        logic [31:0] r = $urandom;
        logic [31:0] base = brk_addr[r[0]*32 +: 32];
        logic [31:0] a = base ^ (r[8:1] & 8'h3f) ^ (r[9] ? 32'h80 : 32'h0);
        access(a, r[11:10], r[12], "R3 random");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule